// File: doc/BRIEF.md
# Asynchronous Serial Character Framer

This block turns bytes into asynchronous serial frames on a transmit line and rebuilds characters from a receive line. Both directions run from one clock. A one-cycle enable, `tick16`, arrives sixteen times per bit cell. Character length, stop length and parity are configuration inputs, sampled while a frame is in flight, and must be held steady for the duration of each frame.

The transmitter accepts a byte through a valid/ready handshake. It sends a start bit, then the data bits least significant first, then an optional parity bit and the stop period. A break input drives the line low for as long as it is held.

The receiver works in three steps:
- It takes a low sample as a candidate start bit and confirms it halfway through the bit cell, so short low glitches are discarded.
- It samples each following bit in the middle of its cell.
- It delivers each character with parity-error, framing-error and break flags.

Baud generation, FIFOs and modem lines sit outside the block.

Top module: `async_framer`

## Requirements
- R1: During and after reset, with no frame started, `txLine` is 1, `txReady` is 1, `rxValid` is 0, and `rxData` and the three receive flags are 0.
- R2: A byte is taken when `txValid` and `txReady` are both 1 at a clock edge, and `txReady` stays 0 until the frame ends. The frame is a 0 start bit, then `cfgLen`+5 data bits least significant first (`cfgLen` 0,1,2,3 selects 5,6,7,8 bits). Each bit lasts 16 ticks. Unused upper bits of `txData` are ignored. While idle the line is 1.
- R3: With `cfgParEn`=1 a parity bit follows the data. With `cfgParOdd`=0 the data ones plus the parity bit give an even count; with `cfgParOdd`=1 they give an odd count. With `cfgParEn`=0 no parity bit is sent.
- R4: The stop period is high. It lasts 16 ticks when `cfgStop`=0. When `cfgStop`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for every other length. `txReady` returns to 1 when the stop period ends.
- R5: While `cfgBreak` is 1, `txLine` is 0 from the next clock on. Once `cfgBreak` is released, the line follows the framer again.
- R6: The receiver detects a start on a low sample at a tick and confirms it at the 8th sample. After that it samples each bit every 16 ticks. On the first stop sample it pulses `rxValid` for one clock, with `rxData` right-aligned and its upper bits 0. `rxData` and the flags hold their values until the next pulse.
- R7: A low level on `rxLine` that lasts fewer than 8 ticks delivers no character, and the receiver then takes the next frame correctly.
- R8: When `cfgParEn`=1 and the received parity bit does not match the mode given in R3, `rxParErr` is 1 for that character. Otherwise it is 0.
- R9: `rxFrameErr` is 1 when the first stop sample is 0. After that the receiver waits for the line to go high before it looks for a new start.
- R10: When the data bits, the parity bit (if enabled) and the first stop sample are all 0, exactly one character is delivered, with `rxData`=0, `rxBreak`=1, `rxFrameErr`=1 and `rxParErr`=0. No further character arrives until the line has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversample enable, 16 per bit |
| cfgLen | input | 2 | Character length code, 5 + value bits |
| cfgStop | input | 1 | 0: one stop bit; 1: two (1.5 for 5-bit) |
| cfgParEn | input | 1 | Parity bit present |
| cfgParOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgBreak | input | 1 | Hold transmit line low |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Transmitter idle and accepting |
| txLine | output | 1 | Serial transmit line |
| rxLine | input | 1 | Serial receive line |
| rxData | output | 8 | Last received character |
| rxValid | output | 1 | One-clock pulse per character |
| rxParErr | output | 1 | Parity mismatch on last character |
| rxFrameErr | output | 1 | Stop sample low on last character |
| rxBreak | output | 1 | Last character was a break |

## Verification
The bench measures the transmitted waveform at bit centres and times each frame against the tick count, so a 1.5-stop setting applied to the wrong length, or a missing parity bit, shows up as a timing or level error. On the receive side it injects a short low glitch. A receiver that does not confirm the start would assemble a spurious character or lose alignment with the next real frame. It also holds the line low for many frames. A receiver that re-arms before the line goes high would deliver a stream of break characters instead of one, and one that does not suppress parity during a break would flag a parity error under odd parity. A framing error is followed by a half-low stop cell, which catches a receiver that restarts on the tail of a bad stop bit.

// File: rtl/async_framer_pkg.sv
package async_framer_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} txState_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rxState_t;
  typedef enum logic [1:0] {LINE_ONE, LINE_ZERO, LINE_DATA, LINE_PAR} lineSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    lineSel_t txSel;
    logic     rxClear;
    logic     rxShift;
    logic     rxParCap;
    logic     rxDeliver;
  } strobe_t;
endpackage

// File: rtl/async_framer_ctrl.sv
module async_framer_ctrl
  import async_framer_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] cfgLen,
  input  logic       cfgStop,
  input  logic       cfgParEn,
  input  logic       txValid,
  input  logic       rxIn,
  output logic       txReady,
  output strobe_t    strb
);
  localparam int CNT_W = $clog2(2 * OVS + 1);
  localparam int MID   = OVS / 2;
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] STOP_1   = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] STOP_15  = CNT_W'(OVS + MID - 1);
  localparam logic [CNT_W-1:0] STOP_2   = CNT_W'(2 * OVS - 1);

  txState_t         txState;
  rxState_t         rxState;
  logic [CNT_W-1:0] txCnt, rxCnt, txLimit, stopEnd;
  logic [2:0]       txBits, rxBits, lastBit;
  logic             txEnd, rxEnd, rxConfirm;

  assign lastBit = 3'd4 + {1'b0, cfgLen};
  always_comb begin
    if (!cfgStop)           stopEnd = STOP_1;
    else if (cfgLen == 2'd0) stopEnd = STOP_15;
    else                    stopEnd = STOP_2;
  end
  assign txLimit   = (txState == TX_STOP) ? stopEnd : BIT_END;
  assign txEnd     = tick && (txCnt == txLimit);
  assign rxEnd     = tick && (rxCnt == BIT_END);
  assign rxConfirm = (rxState == RX_START) && tick && (rxCnt == MID_LAST);
  assign txReady   = (txState == TX_IDLE);

  // transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      txBits  <= '0;
    end else if (txState == TX_IDLE) begin
      if (txValid) begin
        txState <= TX_START;
        txCnt   <= '0;
      end
    end else if (tick) begin
      if (txCnt == txLimit) begin
        txCnt <= '0;
        case (txState)
          TX_START: begin
            txState <= TX_DATA;
            txBits  <= '0;
          end
          TX_DATA:
            if (txBits == lastBit) txState <= cfgParEn ? TX_PAR : TX_STOP;
            else                   txBits  <= txBits + 3'd1;
          TX_PAR:  txState <= TX_STOP;
          default: txState <= TX_IDLE;
        endcase
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBits  <= '0;
    end else begin
      case (rxState)
        RX_IDLE:
          if (tick && !rxIn) begin
            rxState <= RX_START;
            rxCnt   <= CNT_W'(1);
          end
        RX_START:
          if (tick) begin
            if (rxCnt == MID_LAST) begin
              rxCnt   <= '0;
              rxBits  <= '0;
              rxState <= rxIn ? RX_IDLE : RX_DATA;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        RX_WAIT:
          if (rxIn) rxState <= RX_IDLE;
        default:
          if (tick) begin
            if (rxCnt == BIT_END) begin
              rxCnt <= '0;
              case (rxState)
                RX_DATA:
                  if (rxBits == lastBit) rxState <= cfgParEn ? RX_PAR : RX_STOP;
                  else                   rxBits  <= rxBits + 3'd1;
                RX_PAR:  rxState <= RX_STOP;
                default: rxState <= rxIn ? RX_IDLE : RX_WAIT;
              endcase
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
      endcase
    end
  end

  always_comb begin
    strb.txLoad    = (txState == TX_IDLE) && txValid;
    strb.txShift   = (txState == TX_DATA) && txEnd;
    case (txState)
      TX_START: strb.txSel = LINE_ZERO;
      TX_DATA:  strb.txSel = LINE_DATA;
      TX_PAR:   strb.txSel = LINE_PAR;
      default:  strb.txSel = LINE_ONE;
    endcase
    strb.rxClear   = rxConfirm && !rxIn;
    strb.rxShift   = (rxState == RX_DATA) && rxEnd;
    strb.rxParCap  = (rxState == RX_PAR) && rxEnd;
    strb.rxDeliver = (rxState == RX_STOP) && rxEnd;
  end
endmodule

// File: rtl/async_framer_dp.sv
module async_framer_dp
  import async_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgBreak,
  input  logic [WORD_W-1:0] txData,
  input  logic              rxLine,
  output logic              txLine,
  output logic              rxIn,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxBreak
);
  logic [WORD_W-1:0] txSh, rxSh, lenMask, txMasked;
  logic              txParBit, rxParBit, rxMeta, rxSync, rxBreakNow;
  logic [1:0]        shAmt;

  assign shAmt    = 2'd3 - cfgLen;
  assign lenMask  = {WORD_W{1'b1}} >> shAmt;
  assign txMasked = txData & lenMask;
  assign rxIn     = rxSync;
  assign rxBreakNow = !rxSync && (rxSh == '0) && !(cfgParEn && rxParBit);

  // transmit shifter and line register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '0;
      txParBit <= 1'b0;
      txLine   <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txSh     <= txMasked;
        txParBit <= (^txMasked) ^ cfgParOdd;
      end else if (strb.txShift) begin
        txSh <= txSh >> 1;
      end
      if (cfgBreak) txLine <= 1'b0;
      else begin
        case (strb.txSel)
          LINE_ZERO: txLine <= 1'b0;
          LINE_DATA: txLine <= txSh[0];
          LINE_PAR:  txLine <= txParBit;
          default:   txLine <= 1'b1;
        endcase
      end
    end
  end

  // receive synchroniser, assembler and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta     <= 1'b1;
      rxSync     <= 1'b1;
      rxSh       <= '0;
      rxParBit   <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
      rxBreak    <= 1'b0;
    end else begin
      rxMeta  <= rxLine;
      rxSync  <= rxMeta;
      rxValid <= strb.rxDeliver;
      if (strb.rxClear) begin
        rxSh     <= '0;
        rxParBit <= 1'b0;
      end else begin
        if (strb.rxShift)  rxSh     <= {rxSync, rxSh[WORD_W-1:1]};
        if (strb.rxParCap) rxParBit <= rxSync;
      end
      if (strb.rxDeliver) begin
        rxData     <= rxSh >> shAmt;
        rxFrameErr <= !rxSync;
        rxBreak    <= rxBreakNow;
        rxParErr   <= cfgParEn && !rxBreakNow &&
                      (rxParBit != ((^rxSh) ^ cfgParOdd));
      end
    end
  end
endmodule

// File: rtl/async_framer.sv
module async_framer
  import async_framer_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [1:0]        cfgLen,
  input  logic              cfgStop,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgBreak,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxLine,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxBreak
);
  strobe_t strb;
  logic    rxIn;

  async_framer_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .cfgLen(cfgLen), .cfgStop(cfgStop),
    .cfgParEn(cfgParEn), .txValid(txValid), .rxIn(rxIn), .txReady(txReady),
    .strb(strb)
  );

  async_framer_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgLen(cfgLen), .cfgParEn(cfgParEn),
    .cfgParOdd(cfgParOdd), .cfgBreak(cfgBreak), .txData(txData), .rxLine(rxLine),
    .txLine(txLine), .rxIn(rxIn), .rxData(rxData), .rxValid(rxValid),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );
endmodule

// File: rtl/async_framer_chk.sv
module async_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgBreak,
  input logic       txValid,
  input logic       txReady,
  input logic       txLine,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxParErr,
  input logic       rxFrameErr,
  input logic       rxBreak
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && $past(txReady) && !$past(cfgBreak)) |-> txLine);

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  assert_break_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgBreak) |-> !txLine);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxData) && $stable(rxBreak) && $stable(rxFrameErr)));

  assert_break_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |-> (rxData == 8'd0 && rxFrameErr && !rxParErr));
endmodule

bind async_framer async_framer_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgBreak(cfgBreak), .txValid(txValid),
  .txReady(txReady), .txLine(txLine), .rxData(rxData), .rxValid(rxValid),
  .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
);

// File: tb/async_framer_tb.sv
`timescale 1ns/1ps
module async_framer_tb;
  logic clk = 1'b0, rstN = 1'b0, tick16 = 1'b0;
  logic [1:0] cfgLen = 2'd3;
  logic cfgStop = 1'b0, cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgBreak = 1'b0;
  logic [7:0] txData = 8'd0;
  logic txValid = 1'b0, loop = 1'b1, rxDrv = 1'b1;
  logic txReady, txLine, rxValid, rxParErr, rxFrameErr, rxBreak, rxLine;
  logic [7:0] rxData;

  int nChecks = 0, nFail = 0, cyc = 0, tickDiv = 0;
  int rxCount = 0;
  logic [7:0] lastData = 8'd0;
  logic lastPe = 1'b0, lastFe = 1'b0, lastBr = 1'b0;

  assign rxLine = loop ? txLine : rxDrv;

  async_framer u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .cfgLen(cfgLen), .cfgStop(cfgStop),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd), .cfgBreak(cfgBreak),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txLine(txLine),
    .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tick every fourth clock, driven away from the active edge
  always @(negedge clk) begin
    tickDiv <= (tickDiv + 1) % 4;
    tick16  <= (tickDiv == 3);
  end

  // receive monitor
  always @(negedge clk) begin
    if (rxValid) begin
      rxCount  <= rxCount + 1;
      lastData <= rxData;
      lastPe   <= rxParErr;
      lastFe   <= rxFrameErr;
      lastBr   <= rxBreak;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] maskOf(input logic [1:0] len);
    return 8'hFF >> (3 - len);
  endfunction

  task automatic setCfg(input logic [1:0] len, input logic st, input logic pe, input logic po);
    cfgLen = len; cfgStop = st; cfgParEn = pe; cfgParOdd = po;
    waitClk(2);
  endtask

  task automatic expectRx(input int cnt0, input logic [7:0] d, input logic pe,
                          input logic fe, input logic br, input string req);
    check(rxCount == cnt0 + 1, {req, " count"}, rxCount, cnt0 + 1);
    check(lastData == d, {req, " data"}, lastData, d);
    check(lastPe == pe, {req, " parity flag"}, lastPe, pe);
    check(lastFe == fe, {req, " frame flag"}, lastFe, fe);
    check(lastBr == br, {req, " break flag"}, lastBr, br);
  endtask

  // transmit one byte (looped back) and check waveform, timing and reception
  task automatic txFrameTest(input logic [7:0] d, input logic [1:0] len, input logic st,
                             input logic pe, input logic po);
    int t0, dur, nb, expTicks, guard, cnt0;
    logic expPar;
    setCfg(len, st, pe, po);
    loop = 1'b1;
    cnt0 = rxCount;
    nb = 5 + int'(len);
    @(negedge clk); txData = d; txValid = 1'b1;
    @(negedge clk); txValid = 1'b0;
    check(!txReady, "R2 busy after accept", txReady, 0);
    guard = 0;
    while (txLine && guard < 200) begin waitClk(1); guard++; end
    t0 = cyc;
    waitClk(32);
    check(txLine == 1'b0, "R2 start bit", txLine, 0);
    for (int i = 0; i < nb; i++) begin
      waitClk(64);
      check(txLine == d[i], "R2 data bit", txLine, d[i]);
    end
    if (pe) begin
      expPar = (^(d & maskOf(len))) ^ po;
      waitClk(64);
      check(txLine == expPar, "R3 parity bit", txLine, expPar);
    end
    waitClk(64);
    check(txLine == 1'b1, "R4 stop level", txLine, 1);
    guard = 0;
    while (!txReady && guard < 3000) begin waitClk(1); guard++; end
    dur = cyc - t0;
    expTicks = 16 * (1 + nb + int'(pe)) + ((st == 1'b0) ? 16 : ((len == 2'd0) ? 24 : 32));
    check(dur >= 4 * expTicks - 6 && dur <= 4 * expTicks + 6, "R4 frame length",
          dur, 4 * expTicks);
    waitClk(8);
    expectRx(cnt0, d & maskOf(len), 1'b0, 1'b0, 1'b0, "R6 loopback");
  endtask

  // drive one frame onto the receive line
  task automatic rxSend(input logic [7:0] d, input logic flipPar, input logic stopVal);
    int nb;
    nb = 5 + int'(cfgLen);
    loop = 1'b0;
    rxDrv = 1'b0; waitClk(64);
    for (int i = 0; i < nb; i++) begin rxDrv = d[i]; waitClk(64); end
    if (cfgParEn) begin
      rxDrv = (^(d & maskOf(cfgLen))) ^ cfgParOdd ^ flipPar;
      waitClk(64);
    end
    rxDrv = stopVal; waitClk(64);
    rxDrv = 1'b1; waitClk(128);
  endtask

  task automatic testReset;
    check(txLine == 1'b1, "R1 txLine", txLine, 1);
    check(txReady == 1'b1, "R1 txReady", txReady, 1);
    check(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    check(rxData == 8'd0 && !rxParErr && !rxFrameErr && !rxBreak, "R1 rx outputs",
          rxData, 0);
  endtask

  task automatic testTxBreak;
    loop = 1'b0;
    @(negedge clk); cfgBreak = 1'b1;
    waitClk(2);
    check(txLine == 1'b0, "R5 break low", txLine, 0);
    waitClk(100);
    check(txLine == 1'b0, "R5 break held", txLine, 0);
    cfgBreak = 1'b0;
    waitClk(2);
    check(txLine == 1'b1, "R5 release", txLine, 1);
  endtask

  task automatic testRxParity;
    int cnt0;
    setCfg(2'd3, 1'b0, 1'b1, 1'b0);
    cnt0 = rxCount; rxSend(8'h3C, 1'b1, 1'b1);
    expectRx(cnt0, 8'h3C, 1'b1, 1'b0, 1'b0, "R8 even mismatch");
    setCfg(2'd2, 1'b0, 1'b1, 1'b1);
    cnt0 = rxCount; rxSend(8'h55, 1'b0, 1'b1);
    expectRx(cnt0, 8'h55, 1'b0, 1'b0, 1'b0, "R8 odd match");
  endtask

  task automatic testRxFrame;
    int cnt0;
    setCfg(2'd3, 1'b0, 1'b0, 1'b0);
    cnt0 = rxCount; rxSend(8'h5A, 1'b0, 1'b0);
    expectRx(cnt0, 8'h5A, 1'b0, 1'b1, 1'b0, "R9 stop low");
    cnt0 = rxCount; rxSend(8'hC3, 1'b0, 1'b1);
    expectRx(cnt0, 8'hC3, 1'b0, 1'b0, 1'b0, "R9 recovery");
  endtask

  task automatic testRxBreak;
    int cnt0;
    setCfg(2'd3, 1'b0, 1'b1, 1'b1);
    loop = 1'b0;
    cnt0 = rxCount;
    rxDrv = 1'b0; waitClk(64 * 30);
    rxDrv = 1'b1; waitClk(128);
    expectRx(cnt0, 8'h00, 1'b0, 1'b1, 1'b1, "R10 break");
    cnt0 = rxCount; rxSend(8'h96, 1'b0, 1'b1);
    expectRx(cnt0, 8'h96, 1'b0, 1'b0, 1'b0, "R10 after break");
  endtask

  task automatic testGlitch;
    int cnt0;
    setCfg(2'd3, 1'b0, 1'b0, 1'b0);
    loop = 1'b0;
    cnt0 = rxCount;
    rxDrv = 1'b0; waitClk(12); rxDrv = 1'b1; waitClk(64 * 12);
    check(rxCount == cnt0, "R7 short glitch", rxCount, cnt0);
    rxDrv = 1'b0; waitClk(20); rxDrv = 1'b1; waitClk(64 * 12);
    check(rxCount == cnt0, "R7 longer glitch", rxCount, cnt0);
    rxSend(8'h81, 1'b0, 1'b1);
    expectRx(cnt0, 8'h81, 1'b0, 1'b0, 1'b0, "R7 frame after glitch");
  endtask

  initial begin
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(4);
    testReset();
    txFrameTest(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0);
    txFrameTest(8'hF3, 2'd0, 1'b1, 1'b1, 1'b0);
    txFrameTest(8'h4D, 2'd2, 1'b1, 1'b1, 1'b1);
    txFrameTest(8'h2E, 2'd1, 1'b1, 1'b0, 1'b0);
    txFrameTest(8'h01, 2'd3, 1'b0, 1'b1, 1'b1);
    testTxBreak();
    testRxParity();
    testRxFrame();
    testGlitch();
    testRxBreak();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule